// File: doc/BRIEF.md
# GPIO Interrupt Trigger Unit

This block turns activity on general-purpose input pins into interrupt requests. It offers four independent channels. Each channel routes one of 24 input pins through a pin selector, brings it into the clock domain, optionally removes short glitches, and watches it for a rising edge, a falling edge, either edge, a high level or a low level. A hit sets a sticky per-channel pending flag, and the channel's interrupt output follows that flag while the channel is set to a legal mode and a legal pin.

Software reaches the block over a plain register port. A write takes effect on the clock edge where `reg_wen` is high, and reads return data combinationally for the current `reg_addr`. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure. The pins are asynchronous. All other inputs are synchronous to `clk`.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every mode, filter, selector and pending register reads 0 and all `irq_o` bits are 0.
- R2: Selector code k picks pin bit k of `pin_i` for k in 0..23: port A is 0x00–0x07, port B is 0x08–0x0F, and port C is 0x10–0x17. Codes 0x18–0x1F never set pending and hold `irq_o` low.
- R3: Mode field value 1 sets pending on a rising edge, 2 on a falling edge, and 3 on either edge. In those modes the opposite edge has no effect.
- R4: Mode 4 (active high) and mode 5 (active low) set pending on every cycle the active level is present. A clear while the level is still present leaves pending at 1.
- R5: Mode 0 and the reserved modes 6 and 7 never set pending and hold `irq_o` low.
- R6: Config bit 8 enables the filter. With the filter on, a change is taken only after 3 consecutive equal synchronised samples, so a 2-cycle pulse is dropped, a 3-cycle pulse is taken, and an edge reaches `irq_o` 6 clock edges after the pin changes.
- R7: Without the filter, a pin edge in an edge mode reaches `irq_o` on the 3rd rising clock edge after the pin changes: two synchroniser stages, then the detector.
- R8: Pending is sticky. Writing to address 0x20 clears channel n's pending when data bit n is 1. Bits written as 0 leave pending unchanged. Nothing else clears pending.
- R9: When a clear write and a new trigger fall on the same clock edge, pending ends at 1.
- R10: A write to a channel's selector or config register never creates an edge. The previous-sample state reloads from the new source on the cycle after the write.
- R11: `irq_o[n]` is channel n's pending flag ANDed with "mode in 1..5 and selector below 24". Masking the channel leaves pending intact, and unmasking it brings `irq_o` back.
- R12: Channel n's config register is at byte address 4n and its selector register is at 0x10+4n. The pending/clear register is at 0x20. Config reads show only bit 8 (filter) and bits 7:5 (mode). The selector is in bits 4:0. Pending bit n is in bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 24 | Asynchronous general-purpose pins (A0..A7, B0..B7, C0..C7) |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data for `reg_addr` |
| irq_o | output | 4 | Per-channel interrupt request |

## Verification
A software clear of a channel's pending flag can fall on the same clock edge as a fresh trigger on that channel. The bench provokes this by raising the pin and timing the clear write to land on the 3rd edge after the change, which is the detection edge. It judges the outcome by reading pending as 1 afterwards and then checking that a lone clear takes it to 0. Level modes give a second overlap: the bench clears while the level is held and expects pending to stay set.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int MODE_W     = 3;
  localparam int ADDR_W     = 6;
  localparam int MODE_LSB   = 5;
  localparam int FILT_BIT   = 8;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_HIGH = 3'd4,
    TRIG_LOW  = 3'd5,
    TRIG_RSV6 = 3'd6,
    TRIG_RSV7 = 3'd7
  } trig_mode_e;

  // Register banks, decoded from address bits 5:4
  localparam logic [1:0] BANK_CFG = 2'd0;
  localparam logic [1:0] BANK_SEL = 2'd1;
  localparam logic [1:0] BANK_CTL = 2'd2;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m != 3'd0) && (m <= 3'd5);
  endfunction

endpackage

// File: rtl/pirq_sync_bank.sv
module pirq_sync_bank #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/pirq_glitch_filter.sv
module pirq_glitch_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic preload,
  output logic dout
);

  localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic             held;
  logic [CNT_W-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
      run  <= '0;
    end else if (preload) begin
      held <= din;
      run  <= '0;
    end else if (din == held) begin
      run <= '0;
    end else if (run == LAST) begin
      held <= din;
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign dout = held;

endmodule

// File: rtl/pirq_channel.sv
module pirq_channel
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int SEL_W    = 5,
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_s,
  input  logic [SEL_W-1:0]    sel,
  input  logic [MODE_W-1:0]   mode,
  input  logic                filt_en,
  input  logic                reload,
  input  logic                clr,
  output logic                pend_o,
  output logic                live_o
);

  localparam int SPAN = 1 << SEL_W;

  logic [SPAN-1:0] padded;
  logic            cur, fq, det, prev, rise, fall, ev, sel_ok;

  assign padded = SPAN'(pins_s);
  assign cur    = padded[sel];
  assign sel_ok = (sel < SEL_W'(NUM_PINS));

  pirq_glitch_filter #(.LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (cur),
    .preload (reload),
    .dout    (fq)
  );

  assign det  = filt_en ? fq : cur;
  assign rise = det & ~prev & ~reload;
  assign fall = ~det & prev & ~reload;

  always_comb begin
    case (trig_mode_e'(mode))
      TRIG_RISE: ev = rise;
      TRIG_FALL: ev = fall;
      TRIG_BOTH: ev = rise | fall;
      TRIG_HIGH: ev = det;
      TRIG_LOW:  ev = ~det;
      default:   ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev   <= reload ? cur : det;
      pend_o <= (ev & sel_ok) | (pend_o & ~clr);
    end
  end

  assign live_o = sel_ok & mode_legal(mode);

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pirq_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int NUM_CH      = 4,
  parameter int SEL_W       = 5,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_wen,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_CH-1:0]   irq_o
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_PINS-1:0] pins_s;
  logic                word_ok;
  logic [1:0]          bank;
  logic [CH_W-1:0]     chn;

  logic [MODE_W-1:0]   mode_q   [NUM_CH];
  logic [SEL_W-1:0]    sel_q    [NUM_CH];
  logic [NUM_CH-1:0]   filt_q, reload_q, hit_cfg, hit_sel, clr;
  logic [NUM_CH-1:0]   pend_w, live_w;

  assign word_ok = (reg_addr[1:0] == 2'b00);
  assign bank    = reg_addr[5:4];
  assign chn     = reg_addr[2 +: CH_W];

  pirq_sync_bank #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_i),
    .dout  (pins_s)
  );

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      hit_cfg[i] = reg_wen & word_ok & (bank == BANK_CFG) & (chn == CH_W'(i));
      hit_sel[i] = reg_wen & word_ok & (bank == BANK_SEL) & (chn == CH_W'(i));
      clr[i]     = reg_wen & word_ok & (bank == BANK_CTL) & (chn == '0) & reg_wdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        mode_q[i] <= '0;
        sel_q[i]  <= '0;
      end
      filt_q   <= '0;
      reload_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (hit_cfg[i]) begin
          mode_q[i] <= reg_wdata[MODE_LSB +: MODE_W];
          filt_q[i] <= reg_wdata[FILT_BIT];
        end
        if (hit_sel[i]) sel_q[i] <= reg_wdata[SEL_W-1:0];
      end
      reload_q <= hit_cfg | hit_sel;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pirq_channel #(
      .NUM_PINS (NUM_PINS),
      .SEL_W    (SEL_W),
      .FILT_LEN (FILT_LEN)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_s  (pins_s),
      .sel     (sel_q[g]),
      .mode    (mode_q[g]),
      .filt_en (filt_q[g]),
      .reload  (reload_q[g]),
      .clr     (clr[g]),
      .pend_o  (pend_w[g]),
      .live_o  (live_w[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (word_ok) begin
      case (bank)
        BANK_CFG: begin
          reg_rdata[FILT_BIT]            = filt_q[chn];
          reg_rdata[MODE_LSB +: MODE_W]  = mode_q[chn];
        end
        BANK_SEL: reg_rdata[SEL_W-1:0] = sel_q[chn];
        BANK_CTL: if (chn == '0) reg_rdata[NUM_CH-1:0] = pend_w;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign irq_o = pend_w & live_w;

endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [5:0]        reg_addr,
  input logic [NUM_CH-1:0] clr_bits,
  input logic [4:0]        rd_low,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] pend_w,
  input logic [NUM_CH-1:0] live_w
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R11
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> (pend_w[i] && live_w[i]));

    // R5
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_w[i]) |-> $past(live_w[i]));

    // R8
    clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_w[i]) |-> $past(reg_wen && (reg_addr == 6'h20) && clr_bits[i]));

    // R2
    bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !live_w[i] |-> !irq_o[i]);
  end

  // R12
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[5:4] == 2'b00) |-> (rd_low == 5'd0));

endmodule

bind pin_irq_unit pin_irq_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wen  (reg_wen),
  .reg_addr (reg_addr),
  .clr_bits (reg_wdata[NUM_CH-1:0]),
  .rd_low   (reg_rdata[4:0]),
  .irq_o    (irq_o),
  .pend_w   (pend_w),
  .live_w   (live_w)
);

// File: tb/pin_irq_unit_test.sv
module pin_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pins;
  logic        wen;
  logic [5:0]  addr;
  logic [8:0]  wdata;
  logic [8:0]  rdata;
  logic [3:0]  irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pin_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_wen(wen),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [8:0] d);
    wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [8:0] mask, input logic [8:0] exp, input string tag);
    addr = a;
    #1;
    chk((rdata & mask) == exp, tag, int'(rdata & mask), int'(exp));
  endtask

  task automatic set_ch(input int ch, input int sel, input int mode, input bit filt);
    wr(6'(16 + 4*ch), 9'(sel));
    wr(6'(4*ch), {filt, 3'(mode), 5'b0});
    idle(4);
  endtask

  task automatic measure(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    for (int c = 0; c < 4; c++) begin
      rd(6'(4*c), 9'h1FF, 9'h000, "R1 cfg reset");
      rd(6'(16 + 4*c), 9'h1FF, 9'h000, "R1 sel reset");
    end
    rd(6'h20, 9'h1FF, 9'h000, "R1 pending reset");
    chk(irq == 4'b0, "R1 irq reset", int'(irq), 0);
    wr(6'h0C, 9'h1FF);
    rd(6'h0C, 9'h1FF, 9'h1E0, "R12 cfg reserved bits");
    wr(6'h0C, 9'h000);
  endtask

  task automatic t_rise;
    int n;
    set_ch(0, 2, 1, 1'b0);
    wr(6'h20, 9'h001);
    pins[2] = 1'b1;
    measure(0, n);
    chk(n == 3, "R7 unfiltered latency", n, 3);
    rd(6'h20, 9'h00F, 9'h001, "R3 rising sets pending");
  endtask

  task automatic t_sticky;
    pins[2] = 1'b0;
    idle(5);
    rd(6'h20, 9'h00F, 9'h001, "R8 pending sticky");
    wr(6'h20, 9'h002);
    rd(6'h20, 9'h00F, 9'h001, "R8 zero bit no effect");
    wr(6'h20, 9'h001);
    rd(6'h20, 9'h00F, 9'h000, "R8 clear");
    chk(irq[0] == 1'b0, "R8 irq after clear", int'(irq[0]), 0);
    set_ch(0, 0, 0, 1'b0);
  endtask

  task automatic t_fall_both;
    set_ch(1, 13, 2, 1'b0);   // port B pin 5
    wr(6'h20, 9'h002);
    pins[13] = 1'b1; idle(5);
    rd(6'h20, 9'h00F, 9'h000, "R3 falling mode ignores rise");
    pins[13] = 1'b0; idle(5);
    rd(6'h20, 9'h00F, 9'h002, "R3 falling mode, R2 port B");
    set_ch(1, 13, 3, 1'b0);
    wr(6'h20, 9'h002);
    pins[13] = 1'b1; idle(5);
    rd(6'h20, 9'h00F, 9'h002, "R3 both edges rise");
    wr(6'h20, 9'h002);
    pins[13] = 1'b0; idle(5);
    rd(6'h20, 9'h00F, 9'h002, "R3 both edges fall");
    wr(6'h20, 9'h002);
    set_ch(1, 0, 0, 1'b0);
  endtask

  task automatic t_level;
    set_ch(2, 23, 4, 1'b0);   // port C pin 7
    wr(6'h20, 9'h004);
    rd(6'h20, 9'h00F, 9'h000, "R4 high level idle");
    pins[23] = 1'b1; idle(5);
    rd(6'h20, 9'h00F, 9'h004, "R4 high level sets");
    wr(6'h20, 9'h004);
    rd(6'h20, 9'h00F, 9'h004, "R4 clear while level held");
    pins[23] = 1'b0; idle(5);
    wr(6'h20, 9'h004);
    rd(6'h20, 9'h00F, 9'h000, "R4 clear after level gone");
    set_ch(2, 23, 5, 1'b0);
    rd(6'h20, 9'h00F, 9'h004, "R4 low level sets");
    chk(irq[2] == 1'b1, "R4 low level irq", int'(irq[2]), 1);
    pins[23] = 1'b1; idle(5);
    wr(6'h20, 9'h004);
    rd(6'h20, 9'h00F, 9'h000, "R4 low level released");
    set_ch(2, 0, 0, 1'b0);
    pins[23] = 1'b0;
  endtask

  task automatic t_reserved;
    set_ch(3, 24, 1, 1'b0);
    wr(6'h20, 9'h008);
    pins = '1; idle(5);
    pins = '0; idle(5);
    rd(6'h20, 9'h008, 9'h000, "R2 reserved selector");
    chk(irq[3] == 1'b0, "R2 reserved selector irq", int'(irq[3]), 0);
    for (int m = 6; m <= 8; m++) begin
      set_ch(3, 4, m % 8, 1'b0);
      wr(6'h20, 9'h008);
      pins[4] = 1'b1; idle(5);
      pins[4] = 1'b0; idle(5);
      rd(6'h20, 9'h008, 9'h000, "R5 reserved/disabled mode");
      chk(irq[3] == 1'b0, "R5 irq quiet", int'(irq[3]), 0);
    end
  endtask

  task automatic t_filter;
    int n;
    set_ch(0, 6, 1, 1'b1);
    wr(6'h20, 9'h001);
    pins[6] = 1'b1; idle(2); pins[6] = 1'b0; idle(8);
    rd(6'h20, 9'h001, 9'h000, "R6 2-cycle pulse dropped");
    pins[6] = 1'b1; idle(3); pins[6] = 1'b0; idle(8);
    rd(6'h20, 9'h001, 9'h001, "R6 3-cycle pulse taken");
    wr(6'h20, 9'h001);
    pins[6] = 1'b1;
    measure(0, n);
    chk(n == 6, "R6 filtered latency", n, 6);
    pins[6] = 1'b0; idle(8);
    wr(6'h20, 9'h001);
  endtask

  task automatic t_same_cycle;
    set_ch(0, 6, 1, 1'b0);
    wr(6'h20, 9'h001);
    pins[6] = 1'b1;
    idle(2);
    wr(6'h20, 9'h001);        // lands on the detection edge
    rd(6'h20, 9'h001, 9'h001, "R9 trigger beats clear");
    chk(irq[0] == 1'b1, "R9 irq kept", int'(irq[0]), 1);
    wr(6'h20, 9'h001);
    rd(6'h20, 9'h001, 9'h000, "R9 lone clear");
    pins[6] = 1'b0; idle(4);
  endtask

  task automatic t_no_false;
    pins[5] = 1'b0; pins[3] = 1'b1;
    set_ch(0, 5, 1, 1'b0);
    wr(6'h20, 9'h001);
    wr(6'h10, 9'd3);
    idle(6);
    rd(6'h20, 9'h001, 9'h000, "R10 selector switch");
    chk(irq[0] == 1'b0, "R10 irq after selector switch", int'(irq[0]), 0);
    wr(6'h00, 9'h000);
    wr(6'h00, 9'h020);
    idle(6);
    rd(6'h20, 9'h001, 9'h000, "R10 mode re-enable");
    wr(6'h00, 9'h120);
    idle(8);
    rd(6'h20, 9'h001, 9'h000, "R10 filter enable");
    pins[3] = 1'b0; idle(8);
    set_ch(0, 0, 0, 1'b0);
  endtask

  task automatic t_mask;
    set_ch(1, 9, 1, 1'b0);
    wr(6'h20, 9'h002);
    pins[9] = 1'b1; idle(5);
    chk(irq[1] == 1'b1, "R11 irq raised", int'(irq[1]), 1);
    wr(6'h04, 9'h000);
    chk(irq[1] == 1'b0, "R11 masked by mode 0", int'(irq[1]), 0);
    rd(6'h20, 9'h002, 9'h002, "R11 pending kept");
    wr(6'h04, 9'h020);
    chk(irq[1] == 1'b1, "R11 unmasked", int'(irq[1]), 1);
    wr(6'h14, 9'd24);
    chk(irq[1] == 1'b0, "R11 masked by selector", int'(irq[1]), 0);
    pins[9] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins = '0; wen = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_rise();
    t_sticky();
    t_fall_both();
    t_level();
    t_reserved();
    t_filter();
    t_same_cycle();
    t_no_false();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule